// File: doc/BRIEF.md
# SDI Transmit Word Inserter

This block sits in the transmit path of a serial digital video link, just ahead of the serializer. It takes a parallel stream of 10-bit words and rewrites the word positions that the line format reserves. It writes four kinds of content. The first is the four-word timing reference at the start and end of active video. The second is the two line-number words and the third is the two line-CRC words that follow the end-of-active-video code in HD. The fourth is the checksum word that closes every ancillary data packet. Each of the four functions has its own disable input, and a function runs only while that input is low.

In HD mode a luma word and a chroma word arrive on every clock, and each lane is processed on its own. In SD mode the multiplexed stream uses the luma lane only, and the chroma lane passes through unchanged. Line timing comes from a flywheel, which is outside this block. It marks the first word slot of each end-of-active and start-of-active code, and it supplies the field bit, the vertical blanking bit and the 11-bit line number. All outputs are registered, so an output word leaves one clock after its input word.

Top module: `sdi_word_inserter`

## Requirements
- R1: While rst_n is low, both outputs read zero on the next clock. Otherwise each output word equals the input word from one clock earlier, except where R2, R4, R5 or R7 rewrite it.
- R2: With trs_off low, the words starting at an eav_mark or sav_mark cycle are replaced by 3FF, 000, 000, XYZ, on luma always and on chroma in HD. XYZ has bit9=1, bit8=F, bit7=V, bit6=H, bit5=V^H, bit4=F^H, bit3=F^V, bit2=F^V^H and bits 1:0 = 0. H is 1 for the end-of-active code and 0 for the start-of-active code. F and V are the values present at the mark cycle.
- R3: With trs_off high, the four code slots carry the input words unchanged.
- R4: In HD with ln_off low, the two words after each end-of-active code become LN0 and LN1 on both lanes. LN0 bits 8:2 hold the line number bits 6:0. LN1 bits 5:2 hold the line number bits 10:7, and LN1 bits 8:6 are zero. Bit 9 of each word is the inverse of bit 8. The line number is the one present at the eav_mark cycle. In SD mode, or with ln_off high, these slots pass through.
- R5: In HD with crc_off low, the two words after LN1 become CRC0 and CRC1 on both lanes. The CRC uses an 18-bit register r that is zeroed at sav_mark. For each output word from the first active word through LN1, its bits are taken in order 0..9, and for each bit d: fb=r[0]^d, r=r>>1, and if fb then r^=0x23000. CRC0 carries r[8:0] and CRC1 carries r[17:9], each with bit 9 equal to the inverse of bit 8.
- R6: In SD mode, or with crc_off high, the CRC slots carry the input words.
- R7: With anc_off low, an ancillary packet is recognised by the input words 000, 3FF, 3FF on a lane (luma always, chroma in HD only). The word after these is taken as the start of the packet and the next two words follow it; the third word after the pattern holds the count in bits 7:0. The checksum word comes count words later and is replaced by the 9-bit sum of bits 8:0 of every packet word from the first through the last data word, with bit 9 equal to the inverse of bit 8.
- R8: With anc_off high, the checksum word passes through unchanged.
- R9: A count of zero puts the checksum directly after the count word. A 000, 3FF, 3FF pattern inside a packet's data words does not start a new packet.
- R10: In SD mode the chroma lane is passed through with no insertion of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hd_sel | input | 1 | 1 = HD two-lane stream, 0 = SD on luma lane |
| trs_off | input | 1 | High disables timing reference insertion |
| ln_off | input | 1 | High disables line number insertion |
| crc_off | input | 1 | High disables line CRC insertion |
| anc_off | input | 1 | High disables ancillary checksum insertion |
| eav_mark | input | 1 | High on the first word slot of an end-of-active code |
| sav_mark | input | 1 | High on the first word slot of a start-of-active code |
| fld_f | input | 1 | Field bit from the flywheel |
| vblank | input | 1 | Vertical blanking bit from the flywheel |
| line_no | input | 11 | Current line number from the flywheel |
| y_in | input | 10 | Luma (or SD multiplexed) input word |
| c_in | input | 10 | Chroma input word |
| y_out | output | 10 | Luma output word, one clock after input |
| c_out | output | 10 | Chroma output word, one clock after input |

## Verification
The hardest case to reach from the ports is a CRC that covers words this block has itself just written. The end-of-active code and the line numbers are inserted and then fed back into the CRC, so a wrong insertion shows up twice. The stimulus builds whole lines whose code and line-number slots hold junk input. It then runs the same lines with each disable bit set in turn, so the CRC is checked both over the junk and over the generated words. Ancillary packets with a zero count, and packets whose data contain a false header pattern, are placed on both lanes in the same line.

// File: rtl/sdi_ins_pkg.sv
// Shared types, constants and word builders for the SDI word inserter.
// Assumes 10-bit video words and an 18-bit line CRC.
package sdi_ins_pkg;
    localparam int WORD_W  = 10;
    localparam int CRC_W   = 18;
    localparam int HALF_W  = CRC_W / 2;
    localparam int DC_W    = 8;
    localparam int SUM_W   = WORD_W - 1;
    localparam logic [CRC_W-1:0] CRC_MASK = 18'h23000;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ANC_IDLE,
        ANC_HDR0,
        ANC_HDR1,
        ANC_CNT,
        ANC_DATA,
        ANC_SUM
    } anc_phase_e;

    // Build the fourth timing reference word from field, vblank and H.
    function automatic word_t make_xyz(input logic f, input logic v, input logic h);
        word_t w;
        w = '0;
        w[9] = 1'b1;
        w[8] = f;
        w[7] = v;
        w[6] = h;
        w[5] = v ^ h;
        w[4] = f ^ h;
        w[3] = f ^ v;
        w[2] = f ^ v ^ h;
        return w;
    endfunction

    // Advance the line CRC over one word, bit 0 first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input word_t w);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < WORD_W; i++) begin
            fb = r[0] ^ w[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_MASK;
        end
        return r;
    endfunction

    // Protect a 9-bit payload with inverted bit 8 in bit 9.
    function automatic word_t protect9(input logic [SUM_W-1:0] p);
        return {~p[SUM_W-1], p};
    endfunction
endpackage

// File: rtl/sdi_slot_tracker.sv
// Tracks the reserved word slots around the timing reference codes.
// Assumes eav_mark/sav_mark pulse for one clock on the first code slot and
// that marks are at least eight words apart. Produces the TRS and line number
// words, flags the CRC slots and the CRC accumulation window.
module sdi_slot_tracker
    import sdi_ins_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eav_mark,
    input  logic              sav_mark,
    input  logic              fld_f,
    input  logic              vblank,
    input  logic [LINE_W-1:0] line_no,
    output logic              trs_act,
    output word_t             trs_word,
    output logic              ln_act,
    output word_t             ln_word,
    output logic              crc_slot,
    output logic              crc_hi,
    output logic              acc_on,
    output logic              crc_clr
);
    localparam int EAV_SLOTS = 8;
    localparam int SAV_SLOTS = 4;
    localparam int EAV_CW    = $clog2(EAV_SLOTS);
    localparam int SAV_CW    = $clog2(SAV_SLOTS);
    localparam int LN_W      = 11;

    logic [EAV_CW-1:0] eav_cnt, eav_idx;
    logic [SAV_CW-1:0] sav_cnt, sav_idx;
    logic              eav_live, sav_live;
    logic              f_q, v_q;
    logic [LINE_W-1:0] ln_q;
    logic [LN_W-1:0]   ln11;
    logic [1:0]        code_idx;

    // Current slot position within each code region.
    always_comb begin
        eav_live = eav_mark || (eav_cnt != '0);
        sav_live = sav_mark || (sav_cnt != '0);
        eav_idx  = eav_mark ? '0 : eav_cnt;
        sav_idx  = sav_mark ? '0 : sav_cnt;
    end

    // Slot counters that run through each region and wrap to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eav_cnt <= '0;
            sav_cnt <= '0;
        end else begin
            if (eav_mark)             eav_cnt <= EAV_CW'(1);
            else if (eav_cnt != '0)   eav_cnt <= eav_cnt + 1'b1;
            if (sav_mark)             sav_cnt <= SAV_CW'(1);
            else if (sav_cnt != '0)   sav_cnt <= sav_cnt + 1'b1;
        end
    end

    // Capture flywheel timing at each mark for use in later slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q  <= 1'b0;
            v_q  <= 1'b0;
            ln_q <= '0;
        end else begin
            if (eav_mark || sav_mark) begin
                f_q <= fld_f;
                v_q <= vblank;
            end
            if (eav_mark) ln_q <= line_no;
        end
    end

    // CRC window opens after the start code and closes after LN1.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      acc_on <= 1'b0;
        else if (sav_live && sav_idx == SAV_CW'(3))      acc_on <= 1'b1;
        else if (eav_live && eav_idx == EAV_CW'(5))      acc_on <= 1'b0;
    end

    // Timing reference word for the current code slot.
    always_comb begin
        trs_act  = (eav_live && eav_idx <= EAV_CW'(3)) || sav_live;
        code_idx = eav_live ? eav_idx[1:0] : sav_idx[1:0];
        case (code_idx)
            2'd0:    trs_word = '1;
            2'd3:    trs_word = make_xyz(f_q, v_q, eav_live);
            default: trs_word = '0;
        endcase
    end

    // Line number words and CRC slot flags after the end code.
    always_comb begin
        ln11     = LN_W'(ln_q);
        ln_act   = eav_live && (eav_idx == EAV_CW'(4) || eav_idx == EAV_CW'(5));
        if (eav_idx[0]) ln_word = {1'b1, 3'b000, ln11[10:7], 2'b00};
        else            ln_word = {~ln11[6], ln11[6:0], 2'b00};
        crc_slot = eav_live && (eav_idx[EAV_CW-1:1] == 2'b11);
        crc_hi   = eav_idx[0];
        crc_clr  = sav_mark;
    end
endmodule

// File: rtl/sdi_anc_cs.sv
// Finds ancillary packets in one lane of input words and forms the
// checksum for the packet's final word. Assumes the header pattern
// 000,3FF,3FF is followed by two header words and a count word.
module sdi_anc_cs
    import sdi_ins_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  det_en,
    input  word_t word_in,
    output logic  cs_hit,
    output word_t cs_word
);
    localparam word_t ALL_ONES = '1;

    word_t            prev1, prev2;
    anc_phase_e       phase;
    logic [SUM_W-1:0] sum;
    logic [DC_W-1:0]  left;
    logic             hdr_seen;

    // Header detection only between packets.
    always_comb begin
        hdr_seen = det_en && (phase == ANC_IDLE) && (prev2 == '0)
                   && (prev1 == ALL_ONES) && (word_in == ALL_ONES);
        cs_hit   = (phase == ANC_SUM);
        cs_word  = protect9(sum);
    end

    // Two-word history of the lane for pattern matching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev1 <= '0;
            prev2 <= '0;
        end else begin
            prev1 <= word_in;
            prev2 <= prev1;
        end
    end

    // Packet walker: accumulate the sum and count down the data words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ANC_IDLE;
            sum   <= '0;
            left  <= '0;
        end else begin
            case (phase)
                ANC_IDLE: if (hdr_seen) phase <= ANC_HDR0;
                ANC_HDR0: begin
                    sum   <= word_in[SUM_W-1:0];
                    phase <= ANC_HDR1;
                end
                ANC_HDR1: begin
                    sum   <= sum + word_in[SUM_W-1:0];
                    phase <= ANC_CNT;
                end
                ANC_CNT: begin
                    sum   <= sum + word_in[SUM_W-1:0];
                    left  <= word_in[DC_W-1:0];
                    phase <= (word_in[DC_W-1:0] == '0) ? ANC_SUM : ANC_DATA;
                end
                ANC_DATA: begin
                    sum  <= sum + word_in[SUM_W-1:0];
                    left <= left - 1'b1;
                    if (left == DC_W'(1)) phase <= ANC_SUM;
                end
                default: phase <= ANC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdi_line_crc.sv
// Per-lane line CRC register. Clears on the start-code mark and advances
// over each word while the accumulation window is open.
module sdi_line_crc
    import sdi_ins_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             acc,
    input  word_t            word_in,
    output logic [CRC_W-1:0] crc_out
);
    // CRC state update.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc_out <= '0;
        else if (clr) crc_out <= '0;
        else if (acc) crc_out <= crc_step(crc_out, word_in);
    end
endmodule

// File: rtl/sdi_word_inserter.sv
// Transmit-side word inserter: overwrites timing reference, line number,
// line CRC and ancillary checksum slots in a two-lane 10-bit stream.
// Assumes flywheel marks aligned with the input words; output is
// registered with one clock of latency.
module sdi_word_inserter
    import sdi_ins_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_sel,
    input  logic              trs_off,
    input  logic              ln_off,
    input  logic              crc_off,
    input  logic              anc_off,
    input  logic              eav_mark,
    input  logic              sav_mark,
    input  logic              fld_f,
    input  logic              vblank,
    input  logic [LINE_W-1:0] line_no,
    input  logic [9:0]        y_in,
    input  logic [9:0]        c_in,
    output logic [9:0]        y_out,
    output logic [9:0]        c_out
);
    localparam int NUM_LANES = 2;

    logic                        trs_act, ln_act, crc_slot, crc_hi, acc_on, crc_clr;
    word_t                       trs_word, ln_word;
    logic [NUM_LANES-1:0]        anc_hit;
    logic [NUM_LANES*WORD_W-1:0] out_flat;
    word_t                       din [NUM_LANES];

    // Lane 0 carries luma (or the SD stream), lane 1 chroma.
    always_comb begin
        din[0] = y_in;
        din[1] = c_in;
    end

    sdi_slot_tracker #(.LINE_W(LINE_W)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .eav_mark (eav_mark),
        .sav_mark (sav_mark),
        .fld_f    (fld_f),
        .vblank   (vblank),
        .line_no  (line_no),
        .trs_act  (trs_act),
        .trs_word (trs_word),
        .ln_act   (ln_act),
        .ln_word  (ln_word),
        .crc_slot (crc_slot),
        .crc_hi   (crc_hi),
        .acc_on   (acc_on),
        .crc_clr  (crc_clr)
    );

    for (genvar L = 0; L < NUM_LANES; L++) begin : g_lane
        logic             lane_on;
        word_t            cs_w, nxt, out_q;
        logic [CRC_W-1:0] crc_l;

        assign lane_on = (L == 0) || hd_sel;

        sdi_anc_cs u_anc (
            .clk     (clk),
            .rst_n   (rst_n),
            .det_en  (lane_on),
            .word_in (din[L]),
            .cs_hit  (anc_hit[L]),
            .cs_word (cs_w)
        );

        sdi_line_crc u_crc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (crc_clr),
            .acc     (acc_on),
            .word_in (nxt),
            .crc_out (crc_l)
        );

        // Insertion mux; later assignments take priority.
        always_comb begin
            nxt = din[L];
            if (anc_hit[L] && !anc_off) nxt = cs_w;
            if (hd_sel && !crc_off && crc_slot)
                nxt = crc_hi ? protect9(crc_l[CRC_W-1:HALF_W])
                             : protect9(crc_l[HALF_W-1:0]);
            if (hd_sel && !ln_off && ln_act) nxt = ln_word;
            if (lane_on && !trs_off && trs_act) nxt = trs_word;
        end

        // Output register for this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= nxt;
        end

        assign out_flat[L*WORD_W +: WORD_W] = out_q;
    end

    assign y_out = out_flat[WORD_W-1:0];
    assign c_out = out_flat[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/sdi_word_inserter_chk.sv
// Property checker for the SDI word inserter, bound to the top module.
module sdi_word_inserter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hd_sel,
    input logic       trs_off,
    input logic       crc_off,
    input logic       anc_off,
    input logic       eav_mark,
    input logic       sav_mark,
    input logic [9:0] y_in,
    input logic [9:0] c_in,
    input logic [9:0] y_out,
    input logic [9:0] c_out,
    input logic       crc_slot,
    input logic [1:0] anc_hit
);
    AST_EAV_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (eav_mark && !trs_off) |=> (y_out == 10'h3FF)); // R2
    AST_SAV_HEAD_C: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_mark && !trs_off && hd_sel) |=> (c_out == 10'h3FF)); // R2
    AST_TRS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (eav_mark && trs_off) |=> (y_out == $past(y_in))); // R3
    AST_CRC_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_slot && hd_sel && !crc_off) |=> ((y_out[9] != y_out[8]) && (c_out[9] != c_out[8]))); // R5
    AST_ANC_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (anc_hit[0] && !anc_off) |=> (y_out[9] != y_out[8])); // R7
    AST_SD_CHROMA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hd_sel) |=> (c_out == $past(c_in))); // R10
endmodule

bind sdi_word_inserter sdi_word_inserter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hd_sel   (hd_sel),
    .trs_off  (trs_off),
    .crc_off  (crc_off),
    .anc_off  (anc_off),
    .eav_mark (eav_mark),
    .sav_mark (sav_mark),
    .y_in     (y_in),
    .c_in     (c_in),
    .y_out    (y_out),
    .c_out    (c_out),
    .crc_slot (crc_slot),
    .anc_hit  (anc_hit)
);

// File: tb/tb_sdi_word_inserter.sv
`timescale 1ns/1ps
// Line-level bench: builds whole lines, predicts every output word from
// the requirements, and compares each clock.
module tb_sdi_word_inserter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hd_sel = 1'b1, trs_off = 1'b0, ln_off = 1'b0, crc_off = 1'b0, anc_off = 1'b0;
    logic       eav_mark = 1'b0, sav_mark = 1'b0, fld_f = 1'b0, vblank = 1'b0;
    logic [10:0] line_no = '0;
    logic [9:0] y_in = '0, c_in = '0;
    logic [9:0] y_out, c_out;

    always #2 clk = ~clk;

    sdi_word_inserter dut (
        .clk(clk), .rst_n(rst_n), .hd_sel(hd_sel), .trs_off(trs_off), .ln_off(ln_off),
        .crc_off(crc_off), .anc_off(anc_off), .eav_mark(eav_mark), .sav_mark(sav_mark),
        .fld_f(fld_f), .vblank(vblank), .line_no(line_no), .y_in(y_in), .c_in(c_in),
        .y_out(y_out), .c_out(c_out)
    );

    int n_checks = 0, n_errors = 0;
    int qy[$], qc[$], qf[$], qv[$], qln[$], qe[$], qs[$];
    int ey[$], ec[$];
    string ty[$], tc[$];
    int unsigned lcg = 32'h1234_5678;
    bit m_hd, m_trs, m_ln, m_crc, m_anc;

    function automatic int rnd_video();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return 'h040 + int'((lcg >> 16) % 32'h36F);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %03h expected %03h", tag, what, act, exp);
        end
    endtask

    task automatic push_w(int y, int c, int e, int s, int f, int v, int ln);
        qy.push_back(y); qc.push_back(c); qe.push_back(e); qs.push_back(s);
        qf.push_back(f); qv.push_back(v); qln.push_back(ln);
    endtask

    task automatic add_packet(ref int q[$], input int dc, input bit emb);
        q.push_back('h000); q.push_back('h3FF); q.push_back('h3FF);
        q.push_back('h245); q.push_back('h101);
        q.push_back(dc | ((dc & 1) ? 'h100 : 'h200));
        for (int k = 0; k < dc; k++) begin
            if (emb && k == 0)      q.push_back('h000);
            else if (emb && k < 3)  q.push_back('h3FF);
            else                    q.push_back(rnd_video());
        end
        q.push_back('h0AB);
    endtask

    task automatic build_line(int ln, int f, int v, int dcy, int dcc, bit emb);
        int by[$], bc[$];
        int len;
        for (int k = 0; k < 4; k++) push_w('h155 + k, 'h166 + k, k == 0, 0, f, v, ln);
        for (int k = 0; k < 4; k++) push_w('h2A0 + k, 'h2B0 + k, 0, 0, f, v, ln);
        by.push_back('h040); by.push_back('h040);
        bc.push_back('h200); bc.push_back('h200);
        if (dcy >= 0) add_packet(by, dcy, emb);
        if (dcc >= 0) add_packet(bc, dcc, 1'b0);
        len = 24;
        if (by.size() + 2 > len) len = by.size() + 2;
        if (bc.size() + 2 > len) len = bc.size() + 2;
        while (by.size() < len) by.push_back('h040);
        while (bc.size() < len) bc.push_back('h200);
        for (int k = 0; k < len; k++) push_w(by[k], bc[k], 0, 0, f, v, ln);
        for (int k = 0; k < 4; k++) push_w('h177 + k, 'h188 + k, 0, k == 0, f, v, ln);
        for (int k = 0; k < 40; k++) push_w(rnd_video(), rnd_video(), 0, 0, f, v, ln);
    endtask

    function automatic int xyz(int f, int v, int h);
        return 'h200 | (f << 8) | (v << 7) | (h << 6) | ((v ^ h) << 5)
               | ((f ^ h) << 4) | ((f ^ v) << 3) | ((f ^ v ^ h) << 2);
    endfunction

    function automatic int prot(int p);
        return (p & 'h1FF) | ((((p >> 8) & 1) ^ 1) << 9);
    endfunction

    // Reference model for one lane, computed from the requirements.
    task automatic model_lane(int lane, ref int src[$], ref int dst[$], ref string tg[$]);
        int n, j, dc, cs, sum, crc, w, fb, last_e, last_s;
        bit on, acc, emb;
        n = src.size();
        on = (lane == 0) || m_hd;
        dst.delete(); tg.delete();
        for (int i = 0; i < n; i++) begin
            dst.push_back(src[i]);
            tg.push_back(on ? "R1" : "R10");
        end
        // Ancillary packets found on the input words.
        j = 2;
        while (on && j < n) begin
            if (src[j-2] == 'h000 && src[j-1] == 'h3FF && src[j] == 'h3FF) begin
                dc = src[j+3] & 'hFF;
                cs = j + 4 + dc;
                sum = 0;
                emb = (dc == 0);
                for (int k = j + 1; k < cs; k++) begin
                    sum = (sum + (src[k] & 'h1FF)) & 'h1FF;
                    if (k >= j + 6 && src[k] == 'h3FF && src[k-1] == 'h3FF && src[k-2] == 'h000) emb = 1;
                end
                if (m_anc) begin
                    dst[cs] = prot(sum);
                    tg[cs] = emb ? "R9" : "R7";
                end else tg[cs] = "R8";
                j = cs + 1;
            end else j++;
        end
        // Timing reference codes and line numbers.
        for (int i = 0; i < n; i++) begin
            if ((qe[i] || qs[i]) && on) begin
                for (int k = 0; k < 4; k++) tg[i+k] = m_trs ? "R2" : "R3";
                if (m_trs) begin
                    dst[i] = 'h3FF; dst[i+1] = 0; dst[i+2] = 0;
                    dst[i+3] = xyz(qf[i], qv[i], qe[i]);
                end
            end
            if (qe[i] && m_hd) begin
                tg[i+4] = "R4"; tg[i+5] = "R4";
                if (m_ln) begin
                    dst[i+4] = ((qln[i] & 'h7F) << 2) | ((((qln[i] >> 6) & 1) ^ 1) << 9);
                    dst[i+5] = 'h200 | (((qln[i] >> 7) & 'hF) << 2);
                end
            end
        end
        // Line CRC over the finished words.
        crc = 0; acc = 0; last_e = -100; last_s = -100;
        for (int i = 0; i < n; i++) begin
            if (qe[i]) last_e = i;
            if (qs[i]) last_s = i;
            if (m_hd && (i == last_e + 6 || i == last_e + 7)) begin
                tg[i] = m_crc ? "R5" : "R6";
                if (m_crc) dst[i] = (i == last_e + 6) ? prot(crc) : prot(crc >> 9);
            end else if (!m_hd && on && (i == last_e + 6 || i == last_e + 7)) tg[i] = "R6";
            if (acc) begin
                w = dst[i];
                for (int b = 0; b < 10; b++) begin
                    fb = (crc & 1) ^ ((w >> b) & 1);
                    crc = crc >> 1;
                    if (fb) crc = crc ^ 'h23000;
                end
            end
            if (qs[i]) crc = 0;
            if (i == last_s + 3) acc = 1;
            if (i == last_e + 5) acc = 0;
        end
    endtask

    task automatic run_case(string name, bit hd, bit t_off, bit l_off, bit c_off, bit a_off);
        int n;
        qy.delete(); qc.delete(); qf.delete(); qv.delete(); qln.delete(); qe.delete(); qs.delete();
        m_hd = hd; m_trs = !t_off; m_ln = !l_off; m_crc = !c_off; m_anc = !a_off;
        build_line(1, 0, 1, 3, 0, 1'b0);
        build_line(1125, 1, 0, 12, 5, 1'b1);
        build_line('h7FF, 1, 1, 0, -1, 1'b0);
        build_line(42, 0, 0, -1, 2, 1'b0);
        for (int k = 0; k < 4; k++) push_w('h040, 'h200, 0, 0, 0, 0, 0);
        model_lane(0, qy, ey, ty);
        model_lane(1, qc, ec, tc);
        n = qy.size();
        @(negedge clk);
        rst_n = 1'b0; hd_sel = hd; trs_off = t_off; ln_off = l_off; crc_off = c_off; anc_off = a_off;
        y_in = '0; c_in = '0; eav_mark = 0; sav_mark = 0;
        repeat (3) @(negedge clk);
        chk("R1", {name, " reset y_out"}, y_out, 0);
        chk("R1", {name, " reset c_out"}, c_out, 0);
        rst_n = 1'b1;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk(ty[i-1], $sformatf("%s y word %0d", name, i - 1), y_out, ey[i-1]);
                chk(tc[i-1], $sformatf("%s c word %0d", name, i - 1), c_out, ec[i-1]);
            end
            if (i < n) begin
                y_in = 10'(qy[i]); c_in = 10'(qc[i]);
                eav_mark = qe[i][0]; sav_mark = qs[i][0];
                fld_f = qf[i][0]; vblank = qv[i][0]; line_no = 11'(qln[i]);
            end else begin
                y_in = '0; c_in = '0; eav_mark = 0; sav_mark = 0;
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        run_case("hd_all",    1, 0, 0, 0, 0);   // R2 R4 R5 R7 R9
        run_case("hd_trsoff", 1, 1, 0, 0, 0);   // R3
        run_case("hd_lnoff",  1, 0, 1, 0, 0);   // R4 pass-through
        run_case("hd_crcoff", 1, 0, 0, 1, 0);   // R6
        run_case("hd_ancoff", 1, 0, 0, 0, 1);   // R8
        run_case("sd_all",    0, 0, 0, 0, 0);   // R6 R10
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule